// File: doc/BRIEF.md
# Bit-Masked GPIO Port Register File

This block is one eight-pin general-purpose I/O port on a simple memory-mapped register bus. The bus has an address, a write strobe with write data, a read strobe, and registered read data. The port decodes a 4 KB window of byte offsets. Its pin data register appears at 256 word addresses. Address bits [9:2] of each access act as a per-pin mask, so software can set, clear or sample any subset of pins in a single access without a read-modify-write sequence. Each pin also has configuration bits: direction, alternate-function select, digital enable and analog select. A 4-bit function code per pin is held in one 32-bit function register. The port drives pad output and output-enable signals. It samples the pads through a two-stage synchronizer and presents the alternate, analog and function selections to the surrounding pin logic.

A small gate state machine follows the clock-gate enable input. It has three states. `GATE_OFF` is entered at reset and whenever the enable is low. `GATE_WAKE` is a one-cycle settling state entered from `GATE_OFF` when the enable rises. `GATE_ON` is entered from `GATE_WAKE` if the enable is still high. The named transitions are:
- wake (OFF→WAKE)
- settle (WAKE→ON)
- abort (WAKE→OFF)
- drop (ON→OFF)

Bus accesses take effect only in `GATE_ON`. Configuration is kept while the port is gated.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset every register is 0: pad_out, pad_oe, alt_sel_o, ana_sel_o, pin_func_o and bus_rdata are all 0.
- R2: Writes take effect and reads return register contents only in state GATE_ON. GATE_ON is reached one cycle after GATE_WAKE, which is entered on the first edge with clk_en high. A write in the WAKE cycle or while gated is ignored, a read there returns 0, and clk_en low sends the FSM to GATE_OFF on the next edge.
- R3: A write to a word-aligned offset below 0x400 updates pin n only when address bit n+2 is 1, and every other pin keeps its latch value. Offset 0x038 updates exactly bits 1, 2 and 3, and offset 0x3FC updates all eight.
- R4: A read of a word-aligned offset below 0x400 returns the pin values ANDed with address bits [9:2], with bits 31:8 zero.
- R5: The pin value of an output pin (direction 1) is its latch bit. For an input pin it is the synchronized pad bit only when its digital enable is 1 and its analog select is 0, and 0 otherwise.
- R6: A pad input change is invisible to reads captured on the first and second rising edges after it and visible on the third.
- R7: Configuration registers read back what was written: direction at 0x400, alternate select at 0x420, digital enable at 0x51C, analog select at 0x528 (8 bits each, wdata[7:0], read zero-extended), and the 32-bit function register at 0x52C with pin n in bits 4n+3:4n.
- R8: pad_out equals the data latch, and pad_oe[n] = direction & digital enable & ~alternate & ~analog for that pin.
- R9: Undefined offsets, including any offset with address bits [1:0] nonzero, read as 0 and ignore writes.
- R10: alt_sel_o, ana_sel_o and pin_func_o mirror the alternate-select, analog-select and function registers.
- R11: bus_rdata changes only on an edge where bus_re is high, and then holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Clock-gate enable for the port |
| bus_addr | input | 12 | Byte offset within the 4 KB window |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_out | output | 8 | Pad output levels |
| pad_oe | output | 8 | Pad output enables |
| alt_sel_o | output | 8 | Per-pin alternate-function select |
| ana_sel_o | output | 8 | Per-pin analog select |
| pin_func_o | output | 32 | Per-pin 4-bit function codes |

## Verification
The results arrive at different times:
- Writes land on the edge that samples the strobe, so pad_out, pad_oe and the mirror outputs are compared at the following falling edge.
- Read data is registered, so each read drives bus_re for exactly one edge and takes bus_rdata at the next falling edge.
- A pad change needs two synchronizer edges before a read edge can capture it. The bench therefore issues three back-to-back reads after a pad change and expects the old value, the old value, then the new value.

Gate behaviour is timed the same way: one edge into GATE_WAKE, a discarded access on the second, and an effective access from the third.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

    typedef enum logic [1:0] {
        GATE_OFF  = 2'd0,
        GATE_WAKE = 2'd1,
        GATE_ON   = 2'd2
    } gate_state_t;

    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_DATA = 3'd1,
        SEL_DIR  = 3'd2,
        SEL_ALT  = 3'd3,
        SEL_DEN  = 3'd4,
        SEL_ANA  = 3'd5,
        SEL_FUNC = 3'd6
    } reg_sel_t;

    localparam logic [11:0] OFS_DIR  = 12'h400;
    localparam logic [11:0] OFS_ALT  = 12'h420;
    localparam logic [11:0] OFS_DEN  = 12'h51C;
    localparam logic [11:0] OFS_ANA  = 12'h528;
    localparam logic [11:0] OFS_FUNC = 12'h52C;

endpackage

// File: rtl/gpio_gate_fsm.sv
module gpio_gate_fsm
    import gpio_mask_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clk_en,
    output logic access_ok
);

    gate_state_t state_q;
    gate_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GATE_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_OFF:  if (clk_en) state_d = GATE_WAKE;
            GATE_WAKE: state_d = clk_en ? GATE_ON : GATE_OFF;
            GATE_ON:   if (!clk_en) state_d = GATE_OFF;
            default:   state_d = GATE_OFF;
        endcase
    end

    always_comb begin
        access_ok = (state_q == GATE_ON) && clk_en;
    end

    a_r2_settle_to_on: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GATE_WAKE && clk_en) |=> (state_q == GATE_ON));

    a_r2_drop_to_off: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> (state_q == GATE_OFF));

    a_r2_off_never_on: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GATE_OFF) |=> (state_q != GATE_ON));

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stable_q;
    logic             primed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
            primed_q <= 1'b0;
        end else begin
            meta_q   <= async_in;
            stable_q <= meta_q;
            primed_q <= 1'b1;
        end
    end

    assign sync_out = stable_q;

    a_r6_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q |-> (stable_q == $past(meta_q)));

endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_mask_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int PINS   = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel,
    output logic [PINS-1:0]   mask
);

    localparam int MASK_LO = 2;
    localparam int MASK_HI = PINS + 1;

    assign mask = addr[MASK_HI:MASK_LO];

    always_comb begin
        sel = SEL_NONE;
        if (addr[1:0] == 2'b00) begin
            if (addr[ADDR_W-1:MASK_HI+1] == '0) begin
                sel = SEL_DATA;
            end else begin
                case (addr)
                    OFS_DIR:  sel = SEL_DIR;
                    OFS_ALT:  sel = SEL_ALT;
                    OFS_DEN:  sel = SEL_DEN;
                    OFS_ANA:  sel = SEL_ANA;
                    OFS_FUNC: sel = SEL_FUNC;
                    default:  sel = SEL_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_mask_pkg::*;
#(
    parameter int PINS   = 8,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  reg_sel_t            sel,
    input  logic [PINS-1:0]     mask,
    input  logic [DATA_W-1:0]   wdata,
    output logic [PINS-1:0]     latch_q,
    output logic [PINS-1:0]     dir_q,
    output logic [PINS-1:0]     alt_q,
    output logic [PINS-1:0]     den_q,
    output logic [PINS-1:0]     ana_q,
    output logic [4*PINS-1:0]   func_q
);

    localparam int FUNC_W = 4 * PINS;

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                   latch_q[i] <= 1'b0;
            else if (wr_en && sel == SEL_DATA && mask[i]) latch_q[i] <= wdata[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '0;
            alt_q  <= '0;
            den_q  <= '0;
            ana_q  <= '0;
            func_q <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_DIR:  dir_q  <= wdata[PINS-1:0];
                SEL_ALT:  alt_q  <= wdata[PINS-1:0];
                SEL_DEN:  den_q  <= wdata[PINS-1:0];
                SEL_ANA:  ana_q  <= wdata[PINS-1:0];
                SEL_FUNC: func_q <= wdata[FUNC_W-1:0];
                default:  ;
            endcase
        end
    end

    a_r3_unmasked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_DATA) |=> (((latch_q ^ $past(latch_q)) & ~$past(mask)) == '0));

    a_r2_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(latch_q) && $stable(dir_q) && $stable(den_q) && $stable(func_q)));

endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
    import gpio_mask_pkg::*;
#(
    parameter int PINS   = 8,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clk_en,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                bus_re,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [PINS-1:0]     pad_in,
    output logic [PINS-1:0]     pad_out,
    output logic [PINS-1:0]     pad_oe,
    output logic [PINS-1:0]     alt_sel_o,
    output logic [PINS-1:0]     ana_sel_o,
    output logic [4*PINS-1:0]   pin_func_o
);

    localparam int FUNC_W = 4 * PINS;

    logic              access_ok;
    reg_sel_t          sel;
    logic [PINS-1:0]   mask;
    logic [PINS-1:0]   latch_q, dir_q, alt_q, den_q, ana_q;
    logic [FUNC_W-1:0] func_q;
    logic [PINS-1:0]   pad_sync;
    logic [PINS-1:0]   pin_val;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;

    gpio_gate_fsm u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .access_ok (access_ok)
    );

    gpio_addr_decode #(.ADDR_W(ADDR_W), .PINS(PINS)) u_dec (
        .addr (bus_addr),
        .sel  (sel),
        .mask (mask)
    );

    gpio_port_regs #(.PINS(PINS), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_we && access_ok),
        .sel     (sel),
        .mask    (mask),
        .wdata   (bus_wdata),
        .latch_q (latch_q),
        .dir_q   (dir_q),
        .alt_q   (alt_q),
        .den_q   (den_q),
        .ana_q   (ana_q),
        .func_q  (func_q)
    );

    gpio_in_sync #(.WIDTH(PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pad_sync)
    );

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        always_comb begin
            if (dir_q[i])                   pin_val[i] = latch_q[i];
            else if (den_q[i] && !ana_q[i]) pin_val[i] = pad_sync[i];
            else                            pin_val[i] = 1'b0;
        end
        assign pad_oe[i] = dir_q[i] & den_q[i] & ~alt_q[i] & ~ana_q[i];
    end

    always_comb begin
        rd_mux = '0;
        case (sel)
            SEL_DATA: rd_mux[PINS-1:0]   = pin_val & mask;
            SEL_DIR:  rd_mux[PINS-1:0]   = dir_q;
            SEL_ALT:  rd_mux[PINS-1:0]   = alt_q;
            SEL_DEN:  rd_mux[PINS-1:0]   = den_q;
            SEL_ANA:  rd_mux[PINS-1:0]   = ana_q;
            SEL_FUNC: rd_mux[FUNC_W-1:0] = func_q;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_re) rdata_q <= access_ok ? rd_mux : '0;
    end

    assign bus_rdata  = rdata_q;
    assign pad_out    = latch_q;
    assign alt_sel_o  = alt_q;
    assign ana_sel_o  = ana_q;
    assign pin_func_o = func_q;

    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> $stable(bus_rdata));

    a_r2_gated_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && !clk_en) |=> (bus_rdata == '0));

    a_r8_oe_needs_output: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & ~dir_q) == '0) && ((pad_oe & alt_sel_o) == '0));

endmodule

// File: tb/tb_gpio_mask_port.sv
module tb_gpio_mask_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_out, pad_oe, alt_sel_o, ana_sel_o;
    logic [31:0] pin_func_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    gpio_mask_port dut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_re(bus_re), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .alt_sel_o(alt_sel_o), .ana_sel_o(ana_sel_o), .pin_func_o(pin_func_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r, r2;
        logic [7:0] base, val, expv, dir, den, alt, ana, gate;

        repeat (3) @(negedge clk);
        chk("R1 pad_out", {24'b0, pad_out}, 0);
        chk("R1 pad_oe", {24'b0, pad_oe}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 alt_sel_o", {24'b0, alt_sel_o}, 0);
        chk("R1 pin_func_o", pin_func_o, 0);
        chk("R1 rdata", bus_rdata, 0);

        // R2: gated accesses ignored
        wr(12'h3FC, 32'hFF);
        wr(12'h400, 32'hFF);
        chk("R2 gated write pad_out", {24'b0, pad_out}, 0);
        rd(12'h400, r);
        chk("R2 gated read", r, 0);
        clk_en = 1'b1;
        @(negedge clk);                // edge: OFF -> WAKE
        wr(12'h3FC, 32'hA5);           // captured in WAKE, ignored
        chk("R2 wake write ignored", {24'b0, pad_out}, 0);
        wr(12'h3FC, 32'h3C);           // now ON
        chk("R2 on write effective", {24'b0, pad_out}, 32'h3C);

        // R7 / R8 / R10: configuration
        dir = 8'h33; den = 8'h5A; alt = 8'h81; ana = 8'h42;
        wr(12'h400, {24'hFFFFFF, dir});
        wr(12'h51C, {24'hFFFFFF, den});
        wr(12'h420, {24'hFFFFFF, alt});
        wr(12'h528, {24'hFFFFFF, ana});
        wr(12'h52C, 32'h7654_3210);
        rd(12'h400, r); chk("R7 dir readback", r, {24'b0, dir});
        rd(12'h420, r); chk("R7 alt readback", r, {24'b0, alt});
        rd(12'h51C, r); chk("R7 den readback", r, {24'b0, den});
        rd(12'h528, r); chk("R7 ana readback", r, {24'b0, ana});
        rd(12'h52C, r); chk("R7 func readback", r, 32'h7654_3210);
        chk("R10 alt_sel_o", {24'b0, alt_sel_o}, {24'b0, alt});
        chk("R10 ana_sel_o", {24'b0, ana_sel_o}, {24'b0, ana});
        chk("R10 pin_func_o", pin_func_o, 32'h7654_3210);
        chk("R8 pad_oe mixed", {24'b0, pad_oe}, {24'b0, dir & den & ~alt & ~ana});

        // R9: undefined offsets
        wr(12'h404, 32'hFFFF_FFFF);
        wr(12'h800, 32'hFFFF_FFFF);
        wr(12'hFFC, 32'hFFFF_FFFF);
        wr(12'h401, 32'hFFFF_FFFF);
        wr(12'h3FD, 32'hFFFF_FFFF);
        rd(12'h404, r); chk("R9 read 0x404", r, 0);
        rd(12'hFFC, r); chk("R9 read 0xFFC", r, 0);
        rd(12'h52D, r); chk("R9 read misaligned", r, 0);
        rd(12'h400, r); chk("R9 dir untouched", r, {24'b0, dir});
        rd(12'h52C, r); chk("R9 func untouched", r, 32'h7654_3210);
        chk("R9 latch untouched", {24'b0, pad_out}, 32'h3C);

        // all pins output GPIO
        wr(12'h400, 32'hFF); wr(12'h51C, 32'hFF);
        wr(12'h420, 32'h00); wr(12'h528, 32'h00);
        chk("R8 pad_oe all", {24'b0, pad_oe}, 32'hFF);

        // R3: exhaustive mask sweep on writes
        for (int m = 0; m < 256; m++) begin
            base = 8'((m * 37) ^ 8'h5A);
            val  = 8'(~base ^ (m >> 1));
            wr(12'h3FC, {24'b0, base});
            wr(12'(m << 2), {24'hFFFFFF, val});
            expv = (base & ~8'(m)) | (val & 8'(m));
            chk("R3 masked write", {24'b0, pad_out}, {24'b0, expv});
        end
        wr(12'h3FC, 32'h00);
        wr(12'h038, 32'hFF);
        chk("R3 offset 0x038", {24'b0, pad_out}, 32'h0E);

        // R4: exhaustive mask sweep on reads
        wr(12'h3FC, 32'hC3);
        for (int m = 0; m < 256; m++) begin
            rd(12'(m << 2), r);
            chk("R4 masked read", r, {24'b0, 8'hC3 & 8'(m)});
        end

        // R6: synchronizer latency
        wr(12'h400, 32'h0F);
        wr(12'h3FC, 32'hFF);
        pad_in = 8'h5A;
        rd(12'h3FC, r); chk("R6 first edge old", r, 32'h0F);
        rd(12'h3FC, r); chk("R6 second edge old", r, 32'h0F);
        rd(12'h3FC, r); chk("R6 third edge new", r, 32'h5F);

        // R11: hold between reads
        repeat (3) @(negedge clk);
        chk("R11 rdata hold", bus_rdata, 32'h5F);

        // R5: input gating by digital enable and analog select
        dir = 8'h0F; den = 8'h3F; ana = 8'h10;
        wr(12'h51C, {24'b0, den});
        wr(12'h528, {24'b0, ana});
        for (int p = 0; p < 256; p += 17) begin
            pad_in = 8'(p);
            repeat (2) @(negedge clk);
            rd(12'h3FC, r);
            gate = ~dir & den & ~ana;
            chk("R5 pin value", r, {24'b0, (dir & 8'hFF) | (gate & 8'(p))});
        end

        // R2: drop back to OFF
        clk_en = 1'b0;
        @(negedge clk);
        rd(12'h400, r); chk("R2 dropped read", r, 0);
        wr(12'h400, 32'hAA);
        clk_en = 1'b1;
        repeat (2) @(negedge clk);
        rd(12'h400, r2); chk("R2 gated write ignored, config kept", r2, {24'b0, dir});

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule